// File: doc/BRIEF.md
# Integer and Single-Precision Float Conversion Unit

This block converts values between 32-bit two's-complement integers and IEEE-754 binary32 floating point numbers. It serves the conversion instructions of a processor's floating-point extension. One select bit picks the direction. A 2-bit rounding-mode field, taken from the floating-point control/status register, sets how values that cannot be represented exactly are rounded, in either direction.

A conversion is requested by raising `in_valid` for one cycle with the operand, direction and rounding mode. The converted value and two flags are registered. They appear one clock later, together with a one-cycle `out_valid` pulse. The inexact flag reports that nonzero bits were discarded by rounding. The invalid flag reports that a float-to-integer conversion had no representable result and was saturated. Between requests the registered outputs keep their last value.

Top module: `cvt_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high, and low otherwise. While `rst_n` is low, and right after reset, `out_valid`, `result` and both flags are 0.
- R2: With `dir_sel` = 0 (integer to float), every integer whose magnitude fits in 24 bits converts exactly with the inexact flag clear. Integer 0 gives 0x00000000 (+0.0). 0x80000000 gives exactly 0xCF000000 (-2^31).
- R3: Integer-to-float conversion of values with more than 24 significant bits rounds the 24-bit significand by the selected mode, carries into the exponent when rounding overflows, and sets the inexact flag exactly when the discarded bits are nonzero.
- R4: The `round_mode` encoding is 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. The same encoding applies in both conversion directions.
- R5: With `dir_sel` = 1 (float to integer), finite values within the signed 32-bit range round to an integer by the selected mode. This includes zeros and subnormals. The inexact flag is set exactly when a fractional part was discarded.
- R6: Float-to-integer conversion of any NaN (exponent all ones, fraction nonzero, either sign) gives 0x7FFFFFFF with the invalid flag set and the inexact flag clear.
- R7: Float-to-integer conversion of infinities, and of values whose rounded magnitude is outside the signed 32-bit range, saturates to 0x7FFFFFFF for positive inputs and 0x80000000 for negative inputs, with the invalid flag set. -2^31 (0xCF000000) converts exactly to 0x80000000 with no flag.
- R8: In cycles where `in_valid` is low, `result` and both flags keep their previous values, whatever the other inputs do.
- R9: The invalid flag is never set by an integer-to-float conversion, and the inexact and invalid flags are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Conversion request strobe |
| dir_sel | input | 1 | 0: integer to float, 1: float to integer |
| operand | input | 32 | Integer or binary32 source value |
| round_mode | input | 2 | Rounding mode from the control/status field |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Registered converted value |
| flag_inexact | output | 1 | Rounding discarded nonzero bits |
| flag_invalid | output | 1 | Float-to-integer result was saturated |

## Verification
The assertions check several properties on every cycle: the one-cycle latency of `out_valid`, that the outputs hold while no request arrives, that the two flags are mutually exclusive, that integer conversions never raise invalid, and the fixed results for NaN and integer-zero inputs. The rounding arithmetic itself can only be shown by the directed scenarios. These cover ties that go to even in both directions, the carry from the significand into the exponent, the sign-dependent directed modes, subnormal inputs, and the exact boundary at -2^31 against its saturating neighbours.

// File: rtl/cvt_pkg.sv
// Shared types for the conversion unit.
// Assumes the rounding-mode field is two bits with a fixed encoding.
package cvt_pkg;

    // Rounding directions as coded in the control/status field
    typedef enum logic [1:0] {
        RM_NEAR_EVEN   = 2'd0,
        RM_TOWARD_ZERO = 2'd1,
        RM_TOWARD_POS  = 2'd2,
        RM_TOWARD_NEG  = 2'd3
    } round_mode_e;

    // Conversion direction as selected by the request
    typedef enum logic {
        DIR_INT_TO_FLT = 1'b0,
        DIR_FLT_TO_INT = 1'b1
    } conv_dir_e;

endpackage

// File: rtl/cvt_round_dec.sv
// Rounding decision: says whether the kept magnitude must be incremented.
// Assumes sign-magnitude data: lsb is the last kept bit, guard the first
// dropped bit, sticky the OR of all bits dropped below guard.
module cvt_round_dec
    import cvt_pkg::*;
(
    input  logic        sign,
    input  logic        lsb,
    input  logic        guard,
    input  logic        sticky,
    input  round_mode_e mode,
    output logic        incr
);

    // Pick the increment from the mode and the dropped bits
    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN:   incr = guard & (sticky | lsb);
            RM_TOWARD_ZERO: incr = 1'b0;
            RM_TOWARD_POS:  incr = ~sign & (guard | sticky);
            RM_TOWARD_NEG:  incr = sign & (guard | sticky);
            default:        incr = 1'b0;
        endcase
    end

endmodule

// File: rtl/cvt_lzc.sv
// Leading-zero counter. Gives the number of zero bits above the highest
// set bit. Assumes an all-zero input is handled by the caller (count = W).
module cvt_lzc #(
    parameter int W     = 32,
    parameter int CNT_W = $clog2(W) + 1
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);

    // Scan upward so that the highest set bit decides the count
    always_comb begin
        cnt = CNT_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CNT_W'(W - 1 - i);
        end
    end

endmodule

// File: rtl/cvt_itof.sv
// Signed integer to binary floating point converter, combinational.
// Assumes INT_W is wider than the significand by at least two bits and that
// the largest integer exponent fits below the all-ones exponent.
module cvt_itof
    import cvt_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [INT_W-1:0] int_in,
    input  round_mode_e      mode,
    output logic [INT_W-1:0] flt_out,
    output logic             inexact
);

    localparam int SIG_W   = FRAC_W + 1;
    localparam int DROP_W  = INT_W - SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int TOP_EXP = BIAS + INT_W - 1;
    localparam int CNT_W   = $clog2(INT_W) + 1;
    localparam int BODY_W  = EXP_W + FRAC_W;

    logic              sgn;
    logic [INT_W-1:0]  mag;
    logic [INT_W-1:0]  norm;
    logic [CNT_W-1:0]  lz;
    logic [FRAC_W-1:0] frac_kept;
    logic              guard_b;
    logic              sticky_b;
    logic              incr;
    logic              is_zero;
    logic [EXP_W-1:0]  exp_base;
    logic [BODY_W-1:0] body;

    // Take the magnitude of the two's-complement source
    always_comb begin
        sgn = int_in[INT_W-1];
        mag = sgn ? (~int_in + 1'b1) : int_in;
    end

    cvt_lzc #(
        .W     (INT_W),
        .CNT_W (CNT_W)
    ) u_lzc (
        .vec (mag),
        .cnt (lz)
    );

    // Normalise so the leading one lands in the top bit, then split the bits
    always_comb begin
        norm      = mag << lz;
        is_zero   = ~norm[INT_W-1];
        frac_kept = norm[INT_W-2 -: FRAC_W];
        guard_b   = norm[DROP_W-1];
        sticky_b  = |norm[DROP_W-2:0];
    end

    cvt_round_dec u_round (
        .sign   (sgn),
        .lsb    (frac_kept[0]),
        .guard  (guard_b),
        .sticky (sticky_b),
        .mode   (mode),
        .incr   (incr)
    );

    // Add the increment to exponent and fraction as one field so that a
    // fraction overflow carries straight into the exponent
    always_comb begin
        exp_base = EXP_W'(TOP_EXP) - EXP_W'(lz);
        body     = {exp_base, frac_kept} + BODY_W'(incr);
    end

    // Assemble the result; zero needs its own encoding
    always_comb begin
        if (is_zero) begin
            flt_out = '0;
            inexact = 1'b0;
        end else begin
            flt_out = {sgn, body};
            inexact = guard_b | sticky_b;
        end
    end

endmodule

// File: rtl/cvt_ftoi.sv
// Binary floating point to signed integer converter, combinational.
// Assumes the float and integer widths are equal. Out-of-range values and
// NaN saturate and raise invalid; inexact is reported only for finite
// results that lie in range.
module cvt_ftoi
    import cvt_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [INT_W-1:0] flt_in,
    input  round_mode_e      mode,
    output logic [INT_W-1:0] int_out,
    output logic             inexact,
    output logic             invalid
);

    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int TOP_EXP = BIAS + INT_W - 1;
    localparam int SH_W    = $clog2(INT_W);
    localparam int FX_W    = FRAC_W + INT_W;
    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

    logic              sgn;
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;
    logic [SIG_W-1:0]  sig;
    logic              is_nan;
    logic              too_big;
    logic              below_one;
    logic [SH_W-1:0]   sh;
    logic [FX_W-1:0]   fx;
    logic [INT_W-1:0]  ipart;
    logic              guard_b;
    logic              sticky_b;
    logic              incr;
    logic [INT_W:0]    mag;
    logic [INT_W:0]    limit;
    logic              ovf;

    // Split the encoding and classify the exponent
    always_comb begin
        sgn       = flt_in[INT_W-1];
        exp_f     = flt_in[INT_W-2 -: EXP_W];
        frac      = flt_in[FRAC_W-1:0];
        sig       = {1'b1, frac};
        is_nan    = (exp_f == EXP_W'(EXP_MAX)) && (frac != '0);
        too_big   = exp_f > EXP_W'(TOP_EXP);
        below_one = exp_f < EXP_W'(BIAS);
        sh        = SH_W'(exp_f - EXP_W'(BIAS));
    end

    // Place the significand on a fixed point grid with FRAC_W fraction bits
    always_comb begin
        fx = FX_W'(sig) << sh;
    end

    // Extract integer part, guard and sticky for either magnitude range
    always_comb begin
        if (below_one) begin
            ipart    = '0;
            guard_b  = (exp_f == EXP_W'(BIAS - 1));
            sticky_b = guard_b ? (frac != '0) : ((exp_f != '0) || (frac != '0));
        end else begin
            ipart    = fx[FRAC_W +: INT_W];
            guard_b  = fx[FRAC_W-1];
            sticky_b = |fx[FRAC_W-2:0];
        end
    end

    cvt_round_dec u_round (
        .sign   (sgn),
        .lsb    (ipart[0]),
        .guard  (guard_b),
        .sticky (sticky_b),
        .mode   (mode),
        .incr   (incr)
    );

    // Round the magnitude and compare with the sign-dependent limit
    always_comb begin
        mag   = {1'b0, ipart} + (INT_W+1)'(incr);
        limit = {1'b0, sgn, {(INT_W-1){~sgn}}};
        ovf   = mag > limit;
    end

    // Select saturation or the signed rounded value
    always_comb begin
        inexact = 1'b0;
        invalid = 1'b1;
        if (is_nan) begin
            int_out = SAT_POS;
        end else if (too_big || ovf) begin
            int_out = sgn ? SAT_NEG : SAT_POS;
        end else begin
            int_out = sgn ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
            inexact = guard_b | sticky_b;
            invalid = 1'b0;
        end
    end

endmodule

// File: rtl/cvt_unit.sv
// Conversion unit top: selects the direction, registers the result and
// flags, and pulses out_valid one clock after each accepted request.
// Assumes float and integer words share the width INT_W = 1+EXP_W+FRAC_W.
module cvt_unit
    import cvt_pkg::*;
#(
    parameter int INT_W  = 32,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             dir_sel,
    input  logic [INT_W-1:0] operand,
    input  logic [1:0]       round_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] result,
    output logic             flag_inexact,
    output logic             flag_invalid
);

    localparam int EXP_MAX = (1 << EXP_W) - 1;

    round_mode_e      mode;
    conv_dir_e        dir;
    logic [INT_W-1:0] itof_val;
    logic             itof_inx;
    logic [INT_W-1:0] ftoi_val;
    logic             ftoi_inx;
    logic             ftoi_inv;
    logic [INT_W-1:0] nxt_val;
    logic             nxt_inx;
    logic             nxt_inv;

    // Decode the raw control fields into typed values
    always_comb begin
        mode = round_mode_e'(round_mode);
        dir  = conv_dir_e'(dir_sel);
    end

    cvt_itof #(
        .INT_W  (INT_W),
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_itof (
        .int_in  (operand),
        .mode    (mode),
        .flt_out (itof_val),
        .inexact (itof_inx)
    );

    cvt_ftoi #(
        .INT_W  (INT_W),
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_ftoi (
        .flt_in  (operand),
        .mode    (mode),
        .int_out (ftoi_val),
        .inexact (ftoi_inx),
        .invalid (ftoi_inv)
    );

    // Choose the converter output for the requested direction
    always_comb begin
        if (dir == DIR_FLT_TO_INT) begin
            nxt_val = ftoi_val;
            nxt_inx = ftoi_inx;
            nxt_inv = ftoi_inv;
        end else begin
            nxt_val = itof_val;
            nxt_inx = itof_inx;
            nxt_inv = 1'b0;
        end
    end

    // Result register: load on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            flag_inexact <= 1'b0;
            flag_invalid <= 1'b0;
        end else if (in_valid) begin
            result       <= nxt_val;
            flag_inexact <= nxt_inx;
            flag_invalid <= nxt_inv;
        end
    end

    // Valid pulse: follows the request by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag_inexact) && $stable(flag_invalid)));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_inexact && flag_invalid));

    // R9
    itof_no_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_sel) |=> !flag_invalid);

    // R6
    nan_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dir_sel && (operand[INT_W-2 -: EXP_W] == EXP_W'(EXP_MAX))
         && (operand[FRAC_W-1:0] != '0))
        |=> (result == {1'b0, {(INT_W-1){1'b1}}} && flag_invalid));

    // R2
    int_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dir_sel && operand == '0)
        |=> (result == '0 && !flag_inexact));

endmodule

// File: tb/tb_cvt_unit.sv
module tb_cvt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        dir_sel = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  round_mode = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_inexact;
    logic        flag_invalid;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cvt_unit dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .dir_sel      (dir_sel),
        .operand      (operand),
        .round_mode   (round_mode),
        .out_valid    (out_valid),
        .result       (result),
        .flag_inexact (flag_inexact),
        .flag_invalid (flag_invalid)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One request, then check value and flags in the following cycle
    task automatic convert(logic dir, logic [31:0] opnd, logic [1:0] rm,
                           logic [31:0] exp_val, logic exp_inx, logic exp_inv,
                           string tag);
        @(negedge clk);
        in_valid = 1'b1; dir_sel = dir; operand = opnd; round_mode = rm;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 valid"}, {31'b0, out_valid}, 32'd1);
        check({tag, " value"}, result, exp_val);
        check({tag, " inexact"}, {31'b0, flag_inexact}, {31'b0, exp_inx});
        check({tag, " invalid"}, {31'b0, flag_invalid}, {31'b0, exp_inv});
    endtask

    task automatic t_reset();
        in_valid = 1'b1; operand = 32'h3F80_0000; dir_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {31'b0, out_valid}, 32'd0);
        check("R1 flags after reset", {30'b0, flag_inexact, flag_invalid}, 32'd0);
    endtask

    task automatic t_itof_exact();
        convert(1'b0, 32'd0,        2'd0, 32'h0000_0000, 1'b0, 1'b0, "R2 zero");
        convert(1'b0, 32'd1,        2'd3, 32'h3F80_0000, 1'b0, 1'b0, "R2 one");
        convert(1'b0, 32'hFFFF_FFFF, 2'd2, 32'hBF80_0000, 1'b0, 1'b0, "R2 minus one");
        convert(1'b0, 32'd3,        2'd1, 32'h4040_0000, 1'b0, 1'b0, "R2 three");
        convert(1'b0, 32'h8000_0000, 2'd0, 32'hCF00_0000, 1'b0, 1'b0, "R2 most negative");
        convert(1'b0, 32'd16777216, 2'd0, 32'h4B80_0000, 1'b0, 1'b0, "R2 two pow 24");
    endtask

    task automatic t_itof_round();
        // R3 carry into exponent; R4 mode encoding
        convert(1'b0, 32'h7FFF_FFFF, 2'd0, 32'h4F00_0000, 1'b1, 1'b0, "R3 max nearest");
        convert(1'b0, 32'h7FFF_FFFF, 2'd1, 32'h4EFF_FFFF, 1'b1, 1'b0, "R4 max to zero");
        convert(1'b0, 32'h7FFF_FFFF, 2'd2, 32'h4F00_0000, 1'b1, 1'b0, "R4 max up");
        convert(1'b0, 32'h7FFF_FFFF, 2'd3, 32'h4EFF_FFFF, 1'b1, 1'b0, "R4 max down");
        convert(1'b0, 32'd16777217, 2'd0, 32'h4B80_0000, 1'b1, 1'b0, "R3 tie even down");
        convert(1'b0, 32'd16777219, 2'd0, 32'h4B80_0002, 1'b1, 1'b0, "R3 tie even up");
        convert(1'b0, 32'd16777217, 2'd2, 32'h4B80_0001, 1'b1, 1'b0, "R4 tie up");
        convert(1'b0, 32'hFEFF_FFFF, 2'd3, 32'hCB80_0001, 1'b1, 1'b0, "R4 neg down");
        convert(1'b0, 32'hFEFF_FFFF, 2'd2, 32'hCB80_0000, 1'b1, 1'b0, "R4 neg up");
        convert(1'b0, 32'hFEFF_FFFF, 2'd0, 32'hCB80_0000, 1'b1, 1'b0, "R3 neg tie");
    endtask

    task automatic t_ftoi_round();
        convert(1'b1, 32'h3F80_0000, 2'd0, 32'd1,         1'b0, 1'b0, "R5 one");
        convert(1'b1, 32'h4020_0000, 2'd0, 32'd2,         1'b1, 1'b0, "R5 2.5 nearest");
        convert(1'b1, 32'h4060_0000, 2'd0, 32'd4,         1'b1, 1'b0, "R5 3.5 nearest");
        convert(1'b1, 32'h4020_0000, 2'd2, 32'd3,         1'b1, 1'b0, "R4 2.5 up");
        convert(1'b1, 32'h4020_0000, 2'd1, 32'd2,         1'b1, 1'b0, "R4 2.5 to zero");
        convert(1'b1, 32'hC020_0000, 2'd3, 32'hFFFF_FFFD, 1'b1, 1'b0, "R4 -2.5 down");
        convert(1'b1, 32'hC020_0000, 2'd2, 32'hFFFF_FFFE, 1'b1, 1'b0, "R4 -2.5 up");
        convert(1'b1, 32'hC020_0000, 2'd0, 32'hFFFF_FFFE, 1'b1, 1'b0, "R5 -2.5 nearest");
        convert(1'b1, 32'h3F00_0000, 2'd0, 32'd0,         1'b1, 1'b0, "R5 half nearest");
        convert(1'b1, 32'h3F00_0000, 2'd2, 32'd1,         1'b1, 1'b0, "R5 half up");
        convert(1'b1, 32'h3F40_0000, 2'd0, 32'd1,         1'b1, 1'b0, "R5 0.75 nearest");
        convert(1'b1, 32'hBE80_0000, 2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5 -0.25 down");
        convert(1'b1, 32'hBE80_0000, 2'd0, 32'd0,         1'b1, 1'b0, "R5 -0.25 nearest");
        convert(1'b1, 32'h8000_0000, 2'd3, 32'd0,         1'b0, 1'b0, "R5 minus zero");
        convert(1'b1, 32'h0000_0001, 2'd2, 32'd1,         1'b1, 1'b0, "R5 subnormal up");
        convert(1'b1, 32'h0000_0001, 2'd0, 32'd0,         1'b1, 1'b0, "R5 subnormal nearest");
        convert(1'b1, 32'h4B80_0001, 2'd0, 32'h0100_0002, 1'b0, 1'b0, "R5 large exact");
        convert(1'b1, 32'h4EFF_FFFF, 2'd1, 32'h7FFF_FF80, 1'b0, 1'b0, "R5 largest in range");
    endtask

    task automatic t_ftoi_nan();
        convert(1'b1, 32'h7FC0_0000, 2'd0, 32'h7FFF_FFFF, 1'b0, 1'b1, "R6 quiet nan");
        convert(1'b1, 32'hFFC0_0000, 2'd3, 32'h7FFF_FFFF, 1'b0, 1'b1, "R6 negative nan");
        convert(1'b1, 32'h7F80_0001, 2'd1, 32'h7FFF_FFFF, 1'b0, 1'b1, "R6 signalling nan");
    endtask

    task automatic t_ftoi_range();
        convert(1'b1, 32'h7F80_0000, 2'd0, 32'h7FFF_FFFF, 1'b0, 1'b1, "R7 plus inf");
        convert(1'b1, 32'hFF80_0000, 2'd0, 32'h8000_0000, 1'b0, 1'b1, "R7 minus inf");
        convert(1'b1, 32'h4F00_0000, 2'd1, 32'h7FFF_FFFF, 1'b0, 1'b1, "R7 two pow 31");
        convert(1'b1, 32'hCF00_0000, 2'd0, 32'h8000_0000, 1'b0, 1'b0, "R7 exact min");
        convert(1'b1, 32'hCF00_0001, 2'd1, 32'h8000_0000, 1'b0, 1'b1, "R7 below min");
        convert(1'b1, 32'h5F00_0000, 2'd2, 32'h7FFF_FFFF, 1'b0, 1'b1, "R7 far above");
    endtask

    task automatic t_hold();
        convert(1'b1, 32'h4020_0000, 2'd2, 32'd3, 1'b1, 1'b0, "R8 setup");
        dir_sel = 1'b0; operand = 32'h7FFF_FFFF; round_mode = 2'd3;
        repeat (4) begin
            @(negedge clk);
            operand = operand ^ 32'h0F0F_1234;
            dir_sel = ~dir_sel;
        end
        @(negedge clk);
        check("R8 held result", result, 32'd3);
        check("R8 held flags", {30'b0, flag_inexact, flag_invalid}, 32'd2);
        check("R1 no pulse when idle", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; dir_sel = 1'b0; operand = 32'd1; round_mode = 2'd0;
        @(negedge clk);
        check("R1 first pulse", {31'b0, out_valid}, 32'd1);
        check("R1 first value", result, 32'h3F80_0000);
        dir_sel = 1'b1; operand = 32'h7FC0_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 second pulse", {31'b0, out_valid}, 32'd1);
        check("R9 second value", result, 32'h7FFF_FFFF);
        @(negedge clk);
        check("R1 pulse ends", {31'b0, out_valid}, 32'd0);
        check("R9 flags exclusive", {31'b0, flag_inexact & flag_invalid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_itof_exact();
        t_itof_round();
        t_ftoi_round();
        t_ftoi_nan();
        t_ftoi_range();
        t_hold();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule